// File: doc/BRIEF.md
# CPU Interrupt Pending and Delivery Unit

This unit sits between the interrupt sources of a chip and a processor core. It records three kinds of request as pending flags: a reset request, a non-maskable request, and a vector of maskable level requests. Each bit of the level vector lines up with one bit of the core's interrupt mask. At each instruction boundary, flagged by a strobe from the core, it picks at most one exception to raise. It raises it as a one-clock pulse on one of two outputs.

Reset and non-maskable requests share one exception output. Level requests gather by OR into a pending word. That word stays set until a delivery succeeds, which needs the core's interrupt enable set and a pending bit that is unmasked. A blocked level delivery is tried again at every later boundary. The unit never writes the core's cause register.

A two-state controller tracks whether anything is pending. In `ST_IDLE` nothing is pending. In `ST_PEND` at least one flag is set. The transitions are:
- ARRIVE (`ST_IDLE` to `ST_PEND`): a request arrives.
- HOLD (`ST_PEND` to `ST_PEND`): a flag survives the cycle's delivery, or a new request arrives.
- DRAIN (`ST_PEND` to `ST_IDLE`): the last flag is delivered and nothing new arrives.

A check happens only in `ST_PEND` on a cycle where the strobe is high.

Top module: `irq_deliver_unit`

## Requirements
- R1: A synchronous reset (`rst` high) clears all pending flags and holds both exception outputs low. Requests made before the reset are never delivered afterwards.
- R2: Level requests are ORed into the pending word. A bit requested in one cycle and a different bit requested in a later cycle are both pending at the next check.
- R3: A delivery check occurs only when `insn_bnd_i` is high and a flag was already pending before that clock edge. The resulting pulse is visible for exactly the one cycle after that edge.
- R4: Priority at a check is: pending reset first, then pending non-maskable, then pending level. Only one exception is raised per check.
- R5: A pending reset and a pending non-maskable request both pulse `nmi_rst_exc_o`. Each delivery clears only its own flag, so when both are pending they take two checks.
- R6: A level delivery pulses `int_exc_o` only when `sr_ie_i` is 1 and (pending word AND `sr_mask_i`) is nonzero. Bit i of `lvl_req_i` pairs with bit i of `sr_mask_i`.
- R7: A level delivery clears the whole pending word, including bits that were masked.
- R8: A level request blocked by the enable bit or by the mask is retried at every later check, and is delivered once it is enabled and unmasked.
- R9: A request that arrives in the same cycle as a delivery clearing its own flag is kept, and is delivered at a later check.
- R10: At most one exception output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_req_i | input | 1 | Reset request, sampled each cycle |
| nmi_req_i | input | 1 | Non-maskable request, sampled each cycle |
| lvl_req_i | input | LVL_W | Maskable level requests, ORed into the pending word |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| sr_ie_i | input | 1 | Core status: current interrupt enable |
| sr_mask_i | input | LVL_W | Core status: interrupt mask, bit i enables level bit i |
| nmi_rst_exc_o | output | 1 | One-cycle pulse: reset/non-maskable exception |
| int_exc_o | output | 1 | One-cycle pulse: maskable interrupt exception |

## Verification
A request sampled at one clock edge becomes pending after that edge, so a strobe at the same edge does not see it. The earliest check is the strobe at the next edge, and its pulse shows in the cycle that follows. The driver applies one cycle of inputs just after a falling edge and queues the outputs expected after the coming rising edge. The monitor pops and compares at the next falling edge, so every expectation lands exactly one edge after its stimulus. Blocked, masked and same-cycle-arrival cases are each followed by further strobes. These confirm whether a flag survived, using only the two outputs.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RST  = 2'd1,
        SEL_NMI  = 2'd2,
        SEL_LVL  = 2'd3
    } irq_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_st_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend
    import irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req_i,
    input  logic             nmi_req_i,
    input  logic [LVL_W-1:0] lvl_req_i,
    input  irq_sel_e         sel_i,
    output logic             p_rst_o,
    output logic             p_nmi_o,
    output logic [LVL_W-1:0] p_lvl_o
);
    // Clear happens first, new arrivals are ORed on top so none are lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            p_rst_o <= 1'b0;
            p_nmi_o <= 1'b0;
        end else begin
            p_rst_o <= (p_rst_o && (sel_i != SEL_RST)) || rst_req_i;
            p_nmi_o <= (p_nmi_o && (sel_i != SEL_NMI)) || nmi_req_i;
        end
    end

    for (genvar b = 0; b < LVL_W; b++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                p_lvl_o[b] <= 1'b0;
            end else begin
                p_lvl_o[b] <= (p_lvl_o[b] && (sel_i != SEL_LVL)) || lvl_req_i[b];
            end
        end
    end

    // R2 R9
    lvl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_req_i != '0) |=> ((p_lvl_o & $past(lvl_req_i)) == $past(lvl_req_i)));

    // R9
    nmi_keep_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_req_i |=> p_nmi_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             check_i,
    input  logic             p_rst_i,
    input  logic             p_nmi_i,
    input  logic [LVL_W-1:0] p_lvl_i,
    input  logic             sr_ie_i,
    input  logic [LVL_W-1:0] sr_mask_i,
    output irq_sel_e         sel_o
);
    logic lvl_ok;

    always_comb begin
        lvl_ok = sr_ie_i && ((p_lvl_i & sr_mask_i) != '0);
        sel_o  = SEL_NONE;
        if (check_i) begin
            if (p_rst_i)      sel_o = SEL_RST;
            else if (p_nmi_i) sel_o = SEL_NMI;
            else if (lvl_ok)  sel_o = SEL_LVL;
        end
    end
endmodule

// File: rtl/irq_deliver_unit.sv
module irq_deliver_unit
    import irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req_i,
    input  logic             nmi_req_i,
    input  logic [LVL_W-1:0] lvl_req_i,
    input  logic             insn_bnd_i,
    input  logic             sr_ie_i,
    input  logic [LVL_W-1:0] sr_mask_i,
    output logic             nmi_rst_exc_o,
    output logic             int_exc_o
);
    irq_st_e          st_q, st_n;
    irq_sel_e         sel;
    logic             p_rst, p_nmi;
    logic [LVL_W-1:0] p_lvl;
    logic             check;
    logic             arrive, survive;

    irq_pend #(.LVL_W(LVL_W)) pend_i (
        .clk       (clk),
        .rst       (rst),
        .rst_req_i (rst_req_i),
        .nmi_req_i (nmi_req_i),
        .lvl_req_i (lvl_req_i),
        .sel_i     (sel),
        .p_rst_o   (p_rst),
        .p_nmi_o   (p_nmi),
        .p_lvl_o   (p_lvl)
    );

    irq_arbiter #(.LVL_W(LVL_W)) arb_i (
        .check_i   (check),
        .p_rst_i   (p_rst),
        .p_nmi_i   (p_nmi),
        .p_lvl_i   (p_lvl),
        .sr_ie_i   (sr_ie_i),
        .sr_mask_i (sr_mask_i),
        .sel_o     (sel)
    );

    assign check = (st_q == ST_PEND) && insn_bnd_i;

    always_comb begin
        arrive  = rst_req_i || nmi_req_i || (lvl_req_i != '0);
        survive = (p_rst && (sel != SEL_RST)) || (p_nmi && (sel != SEL_NMI)) ||
                  ((p_lvl != '0) && (sel != SEL_LVL));
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: if (arrive) st_n = ST_PEND;                 // ARRIVE
            ST_PEND: if (!arrive && !survive) st_n = ST_IDLE;   // DRAIN, else HOLD
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    // Output pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_rst_exc_o <= 1'b0;
            int_exc_o     <= 1'b0;
        end else begin
            nmi_rst_exc_o <= (sel == SEL_RST) || (sel == SEL_NMI);
            int_exc_o     <= (sel == SEL_LVL);
        end
    end

    // R10
    at_most_one_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_rst_exc_o, int_exc_o}));

    // R3
    exc_after_bnd_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_rst_exc_o || int_exc_o) |-> $past(insn_bnd_i));

    // R3
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (!p_rst && !p_nmi && (p_lvl == '0)));

    // R6
    int_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        int_exc_o |-> $past(sr_ie_i && ((p_lvl & sr_mask_i) != '0)));

    // R4
    int_prio_chk: assert property (@(posedge clk) disable iff (rst)
        int_exc_o |-> $past(!p_rst && !p_nmi));

    // R7
    lvl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (int_exc_o && $past(lvl_req_i == '0)) |-> (p_lvl == '0));
endmodule

// File: tb/irq_deliver_unit_tb_top.sv
module irq_deliver_unit_tb_top;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             rst_req_i, nmi_req_i, insn_bnd_i, sr_ie_i;
    logic [LVL_W-1:0] lvl_req_i, sr_mask_i;
    logic             nmi_rst_exc_o, int_exc_o;

    typedef struct {
        logic  n;
        logic  i;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    irq_deliver_unit #(.LVL_W(LVL_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .rst_req_i     (rst_req_i),
        .nmi_req_i     (nmi_req_i),
        .lvl_req_i     (lvl_req_i),
        .insn_bnd_i    (insn_bnd_i),
        .sr_ie_i       (sr_ie_i),
        .sr_mask_i     (sr_mask_i),
        .nmi_rst_exc_o (nmi_rst_exc_o),
        .int_exc_o     (int_exc_o)
    );

    // Driver: one cycle of stimulus plus the outputs due after the next rising edge
    task automatic cyc(input logic r, input logic rr, input logic nr,
                       input logic [LVL_W-1:0] lv, input logic bnd,
                       input logic ie, input logic [LVL_W-1:0] mk,
                       input logic en, input logic ei, input string tag);
        exp_t e;
        rst = r; rst_req_i = rr; nmi_req_i = nr; lvl_req_i = lv;
        insn_bnd_i = bnd; sr_ie_i = ie; sr_mask_i = mk;
        e.n = en; e.i = ei; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (nmi_rst_exc_o !== e.n || int_exc_o !== e.i) begin
                n_err++;
                $display("FAIL %s: nmi_rst=%b int=%b expected nmi_rst=%b int=%b",
                         e.tag, nmi_rst_exc_o, int_exc_o, e.n, e.i);
            end
            n_chk++;
            if (nmi_rst_exc_o === 1'b1 && int_exc_o === 1'b1) begin
                n_err++;
                $display("FAIL R10: both outputs high, expected at most one");
            end
        end
    end

    localparam logic [LVL_W-1:0] ALL = '1;
    localparam logic [LVL_W-1:0] NO  = '0;

    initial begin
        // R1 reset state
        cyc(1,0,0,NO,0,0,NO, 0,0,"R1");
        cyc(1,0,0,NO,0,0,NO, 0,0,"R1");
        // R3/R6: request, then strobe one edge later
        cyc(0,0,0,6'b000100,1,1,6'b000100, 0,0,"R3");
        cyc(0,0,0,NO,1,1,6'b000100, 0,1,"R3");
        cyc(0,0,0,NO,0,1,6'b000100, 0,0,"R3");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R3");
        // R4/R5: all three pending at once
        cyc(0,1,1,6'b000001,0,1,ALL, 0,0,"R4");
        cyc(0,0,0,NO,1,1,ALL, 1,0,"R4");
        cyc(0,0,0,NO,1,1,ALL, 1,0,"R5");
        cyc(0,0,0,NO,1,1,ALL, 0,1,"R4");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R7");
        // R2/R6/R8/R7: accumulate, blocked, then unmasked
        cyc(0,0,0,6'b000001,0,1,ALL, 0,0,"R2");
        cyc(0,0,0,6'b100000,0,1,ALL, 0,0,"R2");
        cyc(0,0,0,NO,1,0,ALL, 0,0,"R6");
        cyc(0,0,0,NO,1,1,6'b000010, 0,0,"R6");
        cyc(0,0,0,NO,1,1,6'b100000, 0,1,"R8");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R7");
        // R9: level arrival in the delivery cycle
        cyc(0,0,0,6'b000001,0,1,ALL, 0,0,"R9");
        cyc(0,0,0,6'b000010,1,1,ALL, 0,1,"R9");
        cyc(0,0,0,NO,1,1,ALL, 0,1,"R9");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R9");
        // R9: non-maskable arrival in its delivery cycle
        cyc(0,0,1,NO,0,1,ALL, 0,0,"R9");
        cyc(0,0,1,NO,1,1,ALL, 1,0,"R9");
        cyc(0,0,0,NO,1,1,ALL, 1,0,"R9");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R9");
        // R1: reset discards pending requests
        cyc(0,1,1,ALL,0,1,ALL, 0,0,"R1");
        cyc(1,0,0,NO,0,1,ALL, 0,0,"R1");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R1");
        cyc(0,0,0,NO,1,1,ALL, 0,0,"R1");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule